// File: doc/BRIEF.md
# Bit-Manipulation Integer Execution Unit

This block is the integer execution stage of a small 32-bit, three-address processor core. In a single combinational pass it takes an operation code, two register operands (first and second source) and a 16-bit immediate field. It returns the word that the core writes back to the destination register. The operation code alone decides how the immediate is widened: sign-extended, zero-extended, or moved into the upper half of the word.

The unit covers these operations:

- wrap-around add and subtract;
- the low product and the signed and unsigned high products;
- bitwise logic and complement;
- logical and arithmetic shifts, in register and immediate forms;
- compares that write a 0/1 word instead of setting flags.

Codes that name no operation produce a zero word and raise an illegal-operation flag, so the surrounding core can raise an exception. Division, the register file, memory access and control flow belong to other blocks.

Top module: `bmr_alu`

## Requirements
- R1: Codes 0 (add) and 1 (subtract: first minus second) and 2 (low multiply) return the low 32 bits of the exact result, wrapping modulo 2^32.
- R2: Code 3 returns the upper 32 bits of the 64-bit signed product of the two operands; code 4 returns the upper 32 bits of the unsigned product.
- R3: Codes 5, 6 and 7 return the bitwise AND, OR and XOR of the two operands; code 8 returns the one's complement of the first operand.
- R4: Code 12 (add immediate) and code 13 (multiply immediate, low word) sign-extend the 16-bit immediate; codes 15, 16 and 17 (AND, OR, XOR with immediate) zero-extend it.
- R5: Code 14 adds the first operand to the immediate placed in bits 31..16, with bits 15..0 of the addend zero.
- R6: Codes 32+k, for k in 0..9, compare the two operands with relation k, where k = 0 eq, 1 ne, 2 signed lt, 3 signed le, 4 signed gt, 5 signed ge, 6 unsigned lt, 7 unsigned le, 8 unsigned gt, 9 unsigned ge. The result is exactly 1 when the relation holds and 0 otherwise.
- R7: Codes 48+k compare the first operand with the immediate, writing 1 or 0. For k in 0..5, the relation is that of R6 and the immediate is sign-extended. For k in 6..9, the relation is that of R6 and the immediate is zero-extended. For k = 10 and k = 11, the relation is eq and ne, with the immediate zero-extended.
- R8: Codes 9 (shift left), 10 (logical right) and 11 (arithmetic right) shift the first operand by bits 5..0 of the second operand. Left and logical right fill with zeros; arithmetic right fills with copies of bit 31.
- R9: When the register shift amount is 32 to 63, codes 9 and 10 return 0. Code 11 returns all ones when bit 31 of the first operand is set, and 0 otherwise.
- R10: Codes 18, 19 and 20 behave as codes 9, 10 and 11 but take the amount from immediate bits 4..0; immediate bits 15..5 have no effect.
- R11: Codes 21..31, 42..47 and 60..63 return 0 with the illegal flag at 1; every other code holds the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Operation code |
| ra_i | input | 32 | First source operand |
| rb_i | input | 32 | Second source operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Word to write back to the destination |
| illegal_o | output | 1 | High when op_i names no operation |

## Verification
The bound checker watches several invariants at every change of the inputs:

- an illegal code gives a zero word;
- every compare code yields only bit 0;
- register shifts of 32 or more flush the word to zero or to copies of the sign bit;
- subtracting zero returns the first operand unchanged;
- the AND-immediate result stays in the low half;
- the add-shifted-immediate form leaves the low half of the first operand as it was.

The arithmetic values themselves can only be confirmed by the bench, which compares against its own reference model. These values are the high products with mixed signs, wrap-around at the extremes, every compare relation on both sides of the sign boundary, and the handling of the immediate width in each form.

// File: rtl/bmr_alu_pkg.sv
package bmr_alu_pkg;

    localparam int OP_W  = 6;
    localparam int REL_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 6'd0,  OP_SUB   = 6'd1,  OP_MUL   = 6'd2,
        OP_MULHS = 6'd3,  OP_MULHU = 6'd4,  OP_AND   = 6'd5,
        OP_OR    = 6'd6,  OP_XOR   = 6'd7,  OP_NOT   = 6'd8,
        OP_SHL   = 6'd9,  OP_SHR   = 6'd10, OP_SHRS  = 6'd11,
        OP_ADDI  = 6'd12, OP_MULI  = 6'd13, OP_ADDIS = 6'd14,
        OP_ANDI  = 6'd15, OP_ORI   = 6'd16, OP_XORI  = 6'd17,
        OP_SHLI  = 6'd18, OP_SHRI  = 6'd19, OP_SHRSI = 6'd20
    } op_e;

    localparam logic [1:0] CMP_REG_HI = 2'b10;  // codes 32..47
    localparam logic [1:0] CMP_IMM_HI = 2'b11;  // codes 48..63

    typedef enum logic [2:0] {
        U_NONE, U_ADD, U_LOGIC, U_MUL, U_SHIFT, U_CMP
    } unit_e;

    typedef enum logic [1:0] {
        IMM_SX, IMM_ZX, IMM_HI
    } immx_e;

    typedef struct packed {
        unit_e             unit;
        logic [1:0]        sel;
        logic              use_imm;
        immx_e             immx;
        logic [REL_W-1:0]  rel;
        logic              illegal;
    } ctrl_t;

endpackage

// File: rtl/bmr_shifter.sv
module bmr_shifter #(
    parameter int WIDTH = 32,
    localparam int LG   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [LG:0]      amt_i,
    input  logic             right_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] y_o
);
    logic             fill;
    logic [WIDTH-1:0] stage [LG+1];

    assign fill     = right_i & arith_i & a_i[WIDTH-1];
    assign stage[0] = a_i;

    for (genvar g = 0; g < LG; g++) begin : g_stage
        localparam int STEP = 1 << g;
        logic [WIDTH-1:0] moved;
        assign moved = right_i ? {{STEP{fill}}, stage[g][WIDTH-1:STEP]}
                               : {stage[g][WIDTH-1-STEP:0], {STEP{1'b0}}};
        assign stage[g+1] = amt_i[g] ? moved : stage[g];
    end

    // Top amount bit means the whole word has been shifted out.
    assign y_o = amt_i[LG] ? {WIDTH{fill}} : stage[LG];

endmodule

// File: rtl/bmr_multiplier.sv
module bmr_multiplier #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] lo_o,
    output logic [WIDTH-1:0] hi_u_o,
    output logic [WIDTH-1:0] hi_s_o
);
    logic [2*WIDTH-1:0] prod_u;
    logic [WIDTH-1:0]   corr_a;
    logic [WIDTH-1:0]   corr_b;

    assign prod_u = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};
    assign lo_o   = prod_u[WIDTH-1:0];
    assign hi_u_o = prod_u[2*WIDTH-1:WIDTH];
    // Signed high half from the unsigned one: subtract each operand
    // weighted by the other's sign bit.
    assign corr_a = a_i[WIDTH-1] ? b_i : '0;
    assign corr_b = b_i[WIDTH-1] ? a_i : '0;
    assign hi_s_o = hi_u_o - corr_a - corr_b;

endmodule

// File: rtl/bmr_compare.sv
module bmr_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       rel_i,
    output logic             hit_o
);
    logic eq, ltu, lts;

    assign eq  = (a_i == b_i);
    assign ltu = (a_i < b_i);
    assign lts = (a_i[WIDTH-1] != b_i[WIDTH-1]) ? a_i[WIDTH-1] : ltu;

    always_comb begin
        unique case (rel_i)
            4'd0, 4'd10: hit_o = eq;
            4'd1, 4'd11: hit_o = !eq;
            4'd2:        hit_o = lts;
            4'd3:        hit_o = lts | eq;
            4'd4:        hit_o = !(lts | eq);
            4'd5:        hit_o = !lts;
            4'd6:        hit_o = ltu;
            4'd7:        hit_o = ltu | eq;
            4'd8:        hit_o = !(ltu | eq);
            4'd9:        hit_o = !ltu;
            default:     hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bmr_alu.sv
module bmr_alu
    import bmr_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16,
    localparam int LG   = $clog2(WIDTH)
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] ra_i,
    input  logic [WIDTH-1:0] rb_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [WIDTH-1:0] result_o,
    output logic             illegal_o
);
    ctrl_t            ctrl_d;
    logic [WIDTH-1:0] imm_sx_d, imm_zx_d, imm_hi_d, opb_d;
    logic [WIDTH-1:0] sum_d, logic_d, res_d;
    logic [LG:0]      amt_d;
    logic [WIDTH-1:0] mul_lo, mul_hu, mul_hs, shift_y;
    logic             cmp_hit;

    // Decode the operation code into unit, sub-select and operand form.
    always_comb begin
        ctrl_d         = '0;
        ctrl_d.unit    = U_NONE;
        ctrl_d.immx    = IMM_SX;
        ctrl_d.rel     = op_i[REL_W-1:0];
        ctrl_d.illegal = 1'b0;
        case (op_i)
            OP_ADD:   ctrl_d.unit = U_ADD;
            OP_SUB:   begin ctrl_d.unit = U_ADD;   ctrl_d.sel = 2'd1; end
            OP_MUL:   ctrl_d.unit = U_MUL;
            OP_MULHS: begin ctrl_d.unit = U_MUL;   ctrl_d.sel = 2'd1; end
            OP_MULHU: begin ctrl_d.unit = U_MUL;   ctrl_d.sel = 2'd2; end
            OP_AND:   ctrl_d.unit = U_LOGIC;
            OP_OR:    begin ctrl_d.unit = U_LOGIC; ctrl_d.sel = 2'd1; end
            OP_XOR:   begin ctrl_d.unit = U_LOGIC; ctrl_d.sel = 2'd2; end
            OP_NOT:   begin ctrl_d.unit = U_LOGIC; ctrl_d.sel = 2'd3; end
            OP_SHL:   ctrl_d.unit = U_SHIFT;
            OP_SHR:   begin ctrl_d.unit = U_SHIFT; ctrl_d.sel = 2'd1; end
            OP_SHRS:  begin ctrl_d.unit = U_SHIFT; ctrl_d.sel = 2'd2; end
            OP_ADDI:  begin ctrl_d.unit = U_ADD;   ctrl_d.use_imm = 1'b1; end
            OP_MULI:  begin ctrl_d.unit = U_MUL;   ctrl_d.use_imm = 1'b1; end
            OP_ADDIS: begin
                ctrl_d.unit = U_ADD; ctrl_d.use_imm = 1'b1; ctrl_d.immx = IMM_HI;
            end
            OP_ANDI:  begin
                ctrl_d.unit = U_LOGIC; ctrl_d.use_imm = 1'b1; ctrl_d.immx = IMM_ZX;
            end
            OP_ORI:   begin
                ctrl_d.unit = U_LOGIC; ctrl_d.sel = 2'd1;
                ctrl_d.use_imm = 1'b1; ctrl_d.immx = IMM_ZX;
            end
            OP_XORI:  begin
                ctrl_d.unit = U_LOGIC; ctrl_d.sel = 2'd2;
                ctrl_d.use_imm = 1'b1; ctrl_d.immx = IMM_ZX;
            end
            OP_SHLI:  begin ctrl_d.unit = U_SHIFT; ctrl_d.use_imm = 1'b1; end
            OP_SHRI:  begin ctrl_d.unit = U_SHIFT; ctrl_d.sel = 2'd1; ctrl_d.use_imm = 1'b1; end
            OP_SHRSI: begin ctrl_d.unit = U_SHIFT; ctrl_d.sel = 2'd2; ctrl_d.use_imm = 1'b1; end
            default: begin
                if (op_i[OP_W-1 -: 2] == CMP_REG_HI && op_i[REL_W-1:0] <= 4'd9) begin
                    ctrl_d.unit = U_CMP;
                end else if (op_i[OP_W-1 -: 2] == CMP_IMM_HI && op_i[REL_W-1:0] <= 4'd11) begin
                    ctrl_d.unit    = U_CMP;
                    ctrl_d.use_imm = 1'b1;
                    ctrl_d.immx    = (op_i[REL_W-1:0] >= 4'd6) ? IMM_ZX : IMM_SX;
                end else begin
                    ctrl_d.illegal = 1'b1;
                end
            end
        endcase
    end

    // Second operand: register or immediate in one of three widenings.
    always_comb begin
        imm_sx_d = {{(WIDTH-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        imm_zx_d = {{(WIDTH-IMM_W){1'b0}}, imm_i};
        imm_hi_d = imm_zx_d << IMM_W;
        if (!ctrl_d.use_imm)            opb_d = rb_i;
        else if (ctrl_d.immx == IMM_HI) opb_d = imm_hi_d;
        else if (ctrl_d.immx == IMM_ZX) opb_d = imm_zx_d;
        else                            opb_d = imm_sx_d;
        amt_d = ctrl_d.use_imm ? {1'b0, imm_i[LG-1:0]} : rb_i[LG:0];
    end

    bmr_multiplier #(.WIDTH(WIDTH)) u_mul (
        .a_i(ra_i), .b_i(opb_d),
        .lo_o(mul_lo), .hi_u_o(mul_hu), .hi_s_o(mul_hs)
    );

    bmr_shifter #(.WIDTH(WIDTH)) u_shift (
        .a_i(ra_i), .amt_i(amt_d),
        .right_i(ctrl_d.sel != 2'd0), .arith_i(ctrl_d.sel == 2'd2),
        .y_o(shift_y)
    );

    bmr_compare #(.WIDTH(WIDTH)) u_cmp (
        .a_i(ra_i), .b_i(opb_d), .rel_i(ctrl_d.rel), .hit_o(cmp_hit)
    );

    // Result selection.
    always_comb begin
        sum_d = ctrl_d.sel[0] ? (ra_i - opb_d) : (ra_i + opb_d);
        unique case (ctrl_d.sel)
            2'd0:    logic_d = ra_i & opb_d;
            2'd1:    logic_d = ra_i | opb_d;
            2'd2:    logic_d = ra_i ^ opb_d;
            default: logic_d = ~ra_i;
        endcase
        unique case (ctrl_d.unit)
            U_ADD:   res_d = sum_d;
            U_LOGIC: res_d = logic_d;
            U_MUL:   res_d = (ctrl_d.sel == 2'd1) ? mul_hs :
                             (ctrl_d.sel == 2'd2) ? mul_hu : mul_lo;
            U_SHIFT: res_d = shift_y;
            U_CMP:   res_d = {{(WIDTH-1){1'b0}}, cmp_hit};
            default: res_d = '0;
        endcase
    end

    assign result_o  = res_d;
    assign illegal_o = ctrl_d.illegal;

endmodule

// File: rtl/bmr_alu_checker.sv
module bmr_alu_checker
    import bmr_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] ra_i,
    input logic [WIDTH-1:0] rb_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [WIDTH-1:0] result_o,
    input logic             illegal_o
);
    always_comb begin
        if (illegal_o) begin
            p_illegal_zero_r11: assert (result_o == '0);
        end
        if (op_i[OP_W-1] && !illegal_o) begin
            p_cmp_boolean_r6: assert (result_o[WIDTH-1:1] == '0);
        end
        if ((op_i == OP_SHL || op_i == OP_SHR) && rb_i[$clog2(WIDTH)]) begin
            p_shift_flush_r9: assert (result_o == '0);
        end
        if (op_i == OP_SHRS && rb_i[$clog2(WIDTH)]) begin
            p_shrs_flush_r9: assert (result_o == {WIDTH{ra_i[WIDTH-1]}});
        end
        if (op_i == OP_SUB && rb_i == '0) begin
            p_sub_zero_r1: assert (result_o == ra_i);
        end
        if (op_i == OP_ANDI) begin
            p_andi_zext_r4: assert (result_o[WIDTH-1:IMM_W] == '0
                                    && result_o[IMM_W-1:0] == (ra_i[IMM_W-1:0] & imm_i));
        end
        if (op_i == OP_ADDIS) begin
            p_addis_low_r5: assert (result_o[IMM_W-1:0] == ra_i[IMM_W-1:0]);
        end
    end
endmodule

bind bmr_alu bmr_alu_checker #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
    .op_i(op_i), .ra_i(ra_i), .rb_i(rb_i), .imm_i(imm_i),
    .result_o(result_o), .illegal_o(illegal_o)
);

// File: tb/bmr_alu_bench.sv
module bmr_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op;
    logic [31:0] ra, rb;
    logic [15:0] imm;
    logic [31:0] result;
    logic        illegal;
    int          checks = 0;
    int          fails  = 0;

    always #2.5 clk = ~clk;

    bmr_alu u_bmr_alu (
        .op_i(op), .ra_i(ra), .rb_i(rb), .imm_i(imm),
        .result_o(result), .illegal_o(illegal)
    );

    function automatic bit ref_rel(int k, logic [31:0] a, logic [31:0] b);
        case (k)
            0, 10: return a == b;
            1, 11: return a != b;
            2: return $signed(a) <  $signed(b);
            3: return $signed(a) <= $signed(b);
            4: return $signed(a) >  $signed(b);
            5: return $signed(a) >= $signed(b);
            6: return a <  b;
            7: return a <= b;
            8: return a >  b;
            9: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    // Returns {illegal, result}.
    function automatic logic [32:0] ref_alu(int code, logic [31:0] a, logic [31:0] b,
                                            logic [15:0] im);
        logic [31:0]        sx = {{16{im[15]}}, im};
        logic [31:0]        zx = {16'h0, im};
        logic [63:0]        pu = {32'h0, a} * {32'h0, b};
        longint             ps = longint'($signed(a)) * longint'($signed(b));
        logic [63:0]        pi = {32'h0, a} * {32'h0, sx};
        logic [63:0]        wide;
        logic signed [63:0] ext = {{32{a[31]}}, a};
        int                 n   = (code >= 18) ? int'(im[4:0]) : int'(b[5:0]);
        case (code)
            0:  return {1'b0, a + b};
            1:  return {1'b0, a - b};
            2:  return {1'b0, pu[31:0]};
            3:  begin wide = ps; return {1'b0, wide[63:32]}; end
            4:  return {1'b0, pu[63:32]};
            5:  return {1'b0, a & b};
            6:  return {1'b0, a | b};
            7:  return {1'b0, a ^ b};
            8:  return {1'b0, ~a};
            9, 18:  begin wide = {32'h0, a} << n; return {1'b0, wide[31:0]}; end
            10, 19: begin wide = {32'h0, a} >> n; return {1'b0, wide[31:0]}; end
            11, 20: begin wide = ext >>> n;       return {1'b0, wide[31:0]}; end
            12: return {1'b0, a + sx};
            13: return {1'b0, pi[31:0]};
            14: return {1'b0, a + {im, 16'h0}};
            15: return {1'b0, a & zx};
            16: return {1'b0, a | zx};
            17: return {1'b0, a ^ zx};
            default: begin
                if (code >= 32 && code <= 41)
                    return {1'b0, 31'd0, ref_rel(code - 32, a, b)};
                if (code >= 48 && code <= 53)
                    return {1'b0, 31'd0, ref_rel(code - 48, a, sx)};
                if (code >= 54 && code <= 59)
                    return {1'b0, 31'd0, ref_rel(code - 48, a, zx)};
                return {1'b1, 32'h0};
            end
        endcase
    endfunction

    function automatic string tag_of(int code);
        if (code <= 2)                  return "R1";
        if (code <= 4)                  return "R2";
        if (code <= 8)                  return "R3";
        if (code <= 11)                 return "R8";
        if (code == 14)                 return "R5";
        if (code <= 17)                 return "R4";
        if (code <= 20)                 return "R10";
        if (code >= 32 && code <= 41)   return "R6";
        if (code >= 48 && code <= 59)   return "R7";
        return "R11";
    endfunction

    task automatic run(string req, int code, logic [31:0] a, logic [31:0] b,
                       logic [15:0] im);
        logic [32:0] exp;
        @(negedge clk);
        op = 6'(code); ra = a; rb = b; imm = im;
        #1;
        exp = ref_alu(code, a, b, im);
        checks++;
        if (result !== exp[31:0] || illegal !== exp[32]) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h: got %h/%b expected %h/%b",
                     req, code, a, b, im, result, illegal, exp[31:0], exp[32]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        op = '0; ra = '0; rb = '0; imm = '0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state: add of zeros gives zero, flag low (R1).
        run("R1", 0, 32'h0, 32'h0, 16'h0);
        run("R1", 0, 32'hffff_ffff, 32'h1, 16'h0);
        run("R1", 1, 32'h0, 32'h1, 16'h0);
        run("R1", 2, 32'h8000_0001, 32'h0000_0003, 16'h0);
        run("R2", 3, 32'hffff_ffff, 32'hffff_ffff, 16'h0);
        run("R2", 3, 32'h8000_0000, 32'h7fff_ffff, 16'h0);
        run("R2", 4, 32'hffff_ffff, 32'hffff_ffff, 16'h0);
        run("R3", 8, 32'h1234_5678, 32'h0, 16'h0);
        run("R3", 7, 32'hf0f0_f0f0, 32'hff00_ff00, 16'h0);
        run("R4", 12, 32'h10, 32'h0, 16'hffff);
        run("R4", 13, 32'h3, 32'h0, 16'h8000);
        run("R4", 16, 32'h0, 32'h0, 16'h8001);
        run("R4", 15, 32'hffff_ffff, 32'h0, 16'hf00f);
        run("R5", 14, 32'h0000_abcd, 32'h0, 16'h8001);
        run("R6", 34, 32'hffff_ffff, 32'h1, 16'h0);
        run("R6", 38, 32'hffff_ffff, 32'h1, 16'h0);
        run("R6", 37, 32'h5, 32'h5, 16'h0);
        run("R7", 50, 32'hffff_fffe, 32'h0, 16'hffff);
        run("R7", 54, 32'h0000_0005, 32'h0, 16'hffff);
        run("R7", 58, 32'h0000_ffff, 32'h0, 16'hffff);
        run("R7", 48, 32'hffff_ffff, 32'h0, 16'hffff);
        run("R8", 11, 32'h8000_0000, 32'd31, 16'h0);
        run("R8", 10, 32'h8000_0000, 32'd31, 16'h0);
        run("R9", 9, 32'hffff_ffff, 32'd32, 16'h0);
        run("R9", 10, 32'hffff_ffff, 32'd63, 16'h0);
        run("R9", 11, 32'h8000_0000, 32'd40, 16'h0);
        run("R9", 11, 32'h7fff_ffff, 32'd32, 16'h0);
        run("R9", 9, 32'h1, 32'hffff_ffc1, 16'h0);
        run("R10", 18, 32'h1, 32'h0, 16'hffe4);
        run("R10", 20, 32'h8000_0000, 32'h0, 16'h0023);
        run("R11", 21, 32'h1, 32'h1, 16'h1);
        run("R11", 47, 32'h1, 32'h1, 16'h1);
        run("R11", 63, 32'hffff_ffff, 32'hffff_ffff, 16'hffff);
        for (int i = 0; i < 4000; i++) begin
            int          code = int'($urandom_range(0, 63));
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            logic [15:0] im = 16'($urandom);
            case ($urandom_range(0, 3))
                0: begin a = 32'($signed(4'($urandom))); b = 32'($signed(4'($urandom))); end
                1: begin
                    a = a[0] ? 32'h8000_0000 : 32'h7fff_ffff;
                    b = b[0] ? 32'hffff_ffff : 32'h0000_0001;
                end
                2: im = a[15:0];
                default: ;
            endcase
            run(tag_of(code), code, a, b, im);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule